// File: doc/BRIEF.md
# Multi-Mode Load Address Generator

This unit sits in a load path and turns one load request into an effective address, a data memory access and a register write. A request carries a 3-bit mode, a 32-bit immediate or offset, and base, index and destination register numbers. The unit reads the general-purpose register file through two combinational read ports. One port serves the base register and the other serves the index register. The address then comes from one of six schemes: the immediate alone, the base register, base plus offset, base plus index, a pointer fetched from memory, or the base register with a post-update.

The unit handles one request at a time. While it works, `busy` is high and new requests are dropped. The memory port is a simple request/response pair that allows one access in flight. The memory must answer at least one cycle after the request. Pointer mode makes two accesses in a row. Auto-update mode returns the adjusted base value in the same cycle as the loaded data, on a second write port. Mode codes 6 and 7 raise a one-cycle illegal flag and do nothing else.

Top module: `lsagu`

## Requirements
- R1: Mode 0 (absolute) loads from the address equal to the immediate.
- R2: Mode 1 (register indirect) loads from the address held in the base register.
- R3: Mode 2 (displaced) loads from the base register plus the immediate, with 32-bit wrap-around.
- R4: Mode 3 (indexed) loads from the sum of the base register and the index register.
- R5: Mode 4 (memory indirect) makes exactly two accesses. The first is at the base register value. The second is at the word that the first access returned. The result is the data from the second access, and `busy` stays high through the second response.
- R6: Mode 5 (auto-update) loads from the unmodified base value. In the cycle the load result is written, it also writes the base register with base+4 when immediate bit 0 is 0, or base-4 when immediate bit 0 is 1.
- R7: In mode 5, when the destination equals the base register, only the loaded data is written and `baseWrEn` stays low.
- R8: Mode codes 6 and 7 pulse `illegalMode` for exactly one cycle, with no memory request and no register write.
- R9: Register 0 reads as zero on either read port, whatever data the register file returns for it.
- R10: A request presented while `busy` is high is ignored: it causes no memory access and no write.
- R11: Each access raises `memReqValid` for one cycle. The cycle after the final response, `rdWrEn` pulses for one cycle with `rdAddr` equal to the destination and `rdData` equal to the returned word.
- R12: During reset, `busy`, `memReqValid`, `rdWrEn`, `baseWrEn` and `illegalMode` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Load request present (taken when not busy) |
| reqMode | input | 3 | Addressing mode code 0..7 |
| reqImm | input | 32 | Immediate / offset; bit 0 selects decrement in mode 5 |
| reqBase | input | 5 | Base register number |
| reqIndex | input | 5 | Index register number |
| reqDest | input | 5 | Destination register number |
| busy | output | 1 | Request in progress |
| illegalMode | output | 1 | One-cycle flag for codes 6 and 7 |
| rfAddrA | output | 5 | Register file read port A address (base) |
| rfDataA | input | 32 | Register file read port A data |
| rfAddrB | output | 5 | Register file read port B address (index) |
| rfDataB | input | 32 | Register file read port B data |
| memReqValid | output | 1 | Memory read request |
| memAddr | output | 32 | Memory read address |
| memRspValid | input | 1 | Memory read response valid |
| memRspData | input | 32 | Memory read response data |
| rdWrEn | output | 1 | Destination register write enable |
| rdAddr | output | 5 | Destination register number |
| rdData | output | 32 | Loaded data |
| baseWrEn | output | 1 | Base register update enable |
| baseWrAddr | output | 5 | Base register number to update |
| baseWrData | output | 32 | Updated base value |

## Verification
The hardest situation to reach from the ports is a new request arriving in the middle of a pointer-mode load. It must arrive after the first response and before the second, while the memory answers slowly. The bench reaches it by running memory-indirect loads with a response delay of several cycles. During one of them it holds a competing absolute-mode request on the request port until the result appears. It then confirms that exactly two accesses took place and that no stray access or write followed. The bench also covers the case where a loaded value and a base update aim at the same register. It follows that load with a register-indirect load through the same register, so the winning value is seen as the next address.

// File: rtl/agu_pkg.sv
package agu_pkg;

  localparam logic [2:0] MODE_ABS  = 3'd0;
  localparam logic [2:0] MODE_REG  = 3'd1;
  localparam logic [2:0] MODE_DISP = 3'd2;
  localparam logic [2:0] MODE_IDX  = 3'd3;
  localparam logic [2:0] MODE_PTR  = 3'd4;
  localparam logic [2:0] MODE_AUTO = 3'd5;
  localparam logic [2:0] MODE_LAST = MODE_AUTO;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ISSUE1,
    ST_WAIT1,
    ST_ISSUE2,
    ST_WAIT2,
    ST_DONE,
    ST_BAD
  } aguState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capReq;   // latch request fields and first address
    logic capPtr;   // latch fetched pointer as next address
    logic capData;  // latch final loaded word
  } aguStrobe_t;

endpackage

// File: rtl/agu_ea.sv
module agu_ea
  import agu_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [2:0]      mode,
  input  logic [XLEN-1:0] imm,
  input  logic [XLEN-1:0] baseVal,
  input  logic [XLEN-1:0] idxVal,
  output logic [XLEN-1:0] ea
);

  always_comb begin
    unique case (mode)
      MODE_ABS:  ea = imm;
      MODE_DISP: ea = baseVal + imm;
      MODE_IDX:  ea = baseVal + idxVal;
      default:   ea = baseVal;  // register, pointer, auto-update
    endcase
  end

endmodule

// File: rtl/agu_ctrl.sv
module agu_ctrl
  import agu_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [2:0] reqMode,
  input  logic       memRspValid,
  output aguStrobe_t strobe,
  output logic       busy,
  output logic       memReqValid,
  output logic       resultValid,
  output logic       illegalMode
);

  aguState_e state, stateNext;
  logic      isPtr;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      ST_IDLE: if (reqValid) begin
        if (reqMode > MODE_LAST) begin
          stateNext = ST_BAD;
        end else begin
          strobe.capReq = 1'b1;
          stateNext     = ST_ISSUE1;
        end
      end
      ST_ISSUE1: stateNext = ST_WAIT1;
      ST_WAIT1: if (memRspValid) begin
        if (isPtr) begin
          strobe.capPtr = 1'b1;
          stateNext     = ST_ISSUE2;
        end else begin
          strobe.capData = 1'b1;
          stateNext      = ST_DONE;
        end
      end
      ST_ISSUE2: stateNext = ST_WAIT2;
      ST_WAIT2: if (memRspValid) begin
        strobe.capData = 1'b1;
        stateNext      = ST_DONE;
      end
      ST_DONE:  stateNext = ST_IDLE;
      ST_BAD:   stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      isPtr <= 1'b0;
    end else begin
      state <= stateNext;
      if (strobe.capReq) isPtr <= (reqMode == MODE_PTR);
    end
  end

  assign busy        = (state != ST_IDLE);
  assign memReqValid = (state == ST_ISSUE1) || (state == ST_ISSUE2);
  assign resultValid = (state == ST_DONE);
  assign illegalMode = (state == ST_BAD);

endmodule

// File: rtl/agu_dpath.sv
module agu_dpath
  import agu_pkg::*;
#(
  parameter int XLEN         = 32,
  parameter int REG_CNT      = 32,
  parameter int ACCESS_BYTES = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  aguStrobe_t                 strobe,
  input  logic                       resultValid,
  input  logic [2:0]                 reqMode,
  input  logic [XLEN-1:0]            reqImm,
  input  logic [$clog2(REG_CNT)-1:0] reqBase,
  input  logic [$clog2(REG_CNT)-1:0] reqIndex,
  input  logic [$clog2(REG_CNT)-1:0] reqDest,
  output logic [$clog2(REG_CNT)-1:0] rfAddrA,
  input  logic [XLEN-1:0]            rfDataA,
  output logic [$clog2(REG_CNT)-1:0] rfAddrB,
  input  logic [XLEN-1:0]            rfDataB,
  output logic [XLEN-1:0]            memAddr,
  input  logic [XLEN-1:0]            memRspData,
  output logic                       rdWrEn,
  output logic [$clog2(REG_CNT)-1:0] rdAddr,
  output logic [XLEN-1:0]            rdData,
  output logic                       baseWrEn,
  output logic [$clog2(REG_CNT)-1:0] baseWrAddr,
  output logic [XLEN-1:0]            baseWrData
);

  localparam int RIDX = $clog2(REG_CNT);
  localparam logic [XLEN-1:0] STEP = XLEN'(ACCESS_BYTES);

  logic [XLEN-1:0] baseVal, idxVal, ea, stepped;
  logic [XLEN-1:0] addrQ, dataQ, newBaseQ;
  logic [RIDX-1:0] destQ, baseNumQ;
  logic            autoQ;

  assign rfAddrA = reqBase;
  assign rfAddrB = reqIndex;
  // register 0 is hard zero on both ports
  assign baseVal = (reqBase  == '0) ? '0 : rfDataA;
  assign idxVal  = (reqIndex == '0) ? '0 : rfDataB;
  assign stepped = reqImm[0] ? (baseVal - STEP) : (baseVal + STEP);

  agu_ea #(.XLEN(XLEN)) u_ea (
    .mode   (reqMode),
    .imm    (reqImm),
    .baseVal(baseVal),
    .idxVal (idxVal),
    .ea     (ea)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ    <= '0;
      dataQ    <= '0;
      newBaseQ <= '0;
      destQ    <= '0;
      baseNumQ <= '0;
      autoQ    <= 1'b0;
    end else begin
      if (strobe.capReq) begin
        addrQ    <= ea;
        destQ    <= reqDest;
        baseNumQ <= reqBase;
        autoQ    <= (reqMode == MODE_AUTO);
        newBaseQ <= stepped;
      end
      if (strobe.capPtr)  addrQ <= memRspData;
      if (strobe.capData) dataQ <= memRspData;
    end
  end

  assign memAddr    = addrQ;
  assign rdWrEn     = resultValid;
  assign rdAddr     = destQ;
  assign rdData     = dataQ;
  // loaded data wins when both writes name the same register
  assign baseWrEn   = resultValid && autoQ && (baseNumQ != destQ);
  assign baseWrAddr = baseNumQ;
  assign baseWrData = newBaseQ;

endmodule

// File: rtl/lsagu.sv
module lsagu
  import agu_pkg::*;
#(
  parameter int XLEN         = 32,
  parameter int REG_CNT      = 32,
  parameter int ACCESS_BYTES = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       reqValid,
  input  logic [2:0]                 reqMode,
  input  logic [XLEN-1:0]            reqImm,
  input  logic [$clog2(REG_CNT)-1:0] reqBase,
  input  logic [$clog2(REG_CNT)-1:0] reqIndex,
  input  logic [$clog2(REG_CNT)-1:0] reqDest,
  output logic                       busy,
  output logic                       illegalMode,
  output logic [$clog2(REG_CNT)-1:0] rfAddrA,
  input  logic [XLEN-1:0]            rfDataA,
  output logic [$clog2(REG_CNT)-1:0] rfAddrB,
  input  logic [XLEN-1:0]            rfDataB,
  output logic                       memReqValid,
  output logic [XLEN-1:0]            memAddr,
  input  logic                       memRspValid,
  input  logic [XLEN-1:0]            memRspData,
  output logic                       rdWrEn,
  output logic [$clog2(REG_CNT)-1:0] rdAddr,
  output logic [XLEN-1:0]            rdData,
  output logic                       baseWrEn,
  output logic [$clog2(REG_CNT)-1:0] baseWrAddr,
  output logic [XLEN-1:0]            baseWrData
);

  aguStrobe_t strobe;
  logic       resultValid;

  agu_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqMode    (reqMode),
    .memRspValid(memRspValid),
    .strobe     (strobe),
    .busy       (busy),
    .memReqValid(memReqValid),
    .resultValid(resultValid),
    .illegalMode(illegalMode)
  );

  agu_dpath #(
    .XLEN        (XLEN),
    .REG_CNT     (REG_CNT),
    .ACCESS_BYTES(ACCESS_BYTES)
  ) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .resultValid(resultValid),
    .reqMode    (reqMode),
    .reqImm     (reqImm),
    .reqBase    (reqBase),
    .reqIndex   (reqIndex),
    .reqDest    (reqDest),
    .rfAddrA    (rfAddrA),
    .rfDataA    (rfDataA),
    .rfAddrB    (rfAddrB),
    .rfDataB    (rfDataB),
    .memAddr    (memAddr),
    .memRspData (memRspData),
    .rdWrEn     (rdWrEn),
    .rdAddr     (rdAddr),
    .rdData     (rdData),
    .baseWrEn   (baseWrEn),
    .baseWrAddr (baseWrAddr),
    .baseWrData (baseWrData)
  );

endmodule

// File: rtl/lsagu_checker.sv
module lsagu_checker #(
  parameter int RIDX = 5
) (
  input logic            clk,
  input logic            rstN,
  input logic            reqValid,
  input logic            busy,
  input logic            illegalMode,
  input logic            memReqValid,
  input logic            memRspValid,
  input logic            rdWrEn,
  input logic [RIDX-1:0] rdAddr,
  input logic            baseWrEn,
  input logic [RIDX-1:0] baseWrAddr
);

  p_req_single_r11: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |=> !memReqValid);

  p_wr_pulse_r11: assert property (@(posedge clk) disable iff (!rstN)
    rdWrEn |=> !rdWrEn);

  p_result_after_rsp_r5: assert property (@(posedge clk) disable iff (!rstN)
    rdWrEn |-> $past(memRspValid));

  p_base_with_data_r6: assert property (@(posedge clk) disable iff (!rstN)
    baseWrEn |-> rdWrEn);

  p_data_wins_r7: assert property (@(posedge clk) disable iff (!rstN)
    baseWrEn |-> (baseWrAddr != rdAddr));

  p_illegal_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    illegalMode |-> (!memReqValid && !rdWrEn && !baseWrEn && $past(reqValid)));

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!memReqValid && !rdWrEn && !illegalMode));

  always_comb begin
    if (!rstN) begin
      a_reset_quiet_r12: assert (!memReqValid || $isunknown(memReqValid));
    end
  end

endmodule

bind lsagu lsagu_checker #(.RIDX($clog2(REG_CNT))) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .reqValid   (reqValid),
  .busy       (busy),
  .illegalMode(illegalMode),
  .memReqValid(memReqValid),
  .memRspValid(memRspValid),
  .rdWrEn     (rdWrEn),
  .rdAddr     (rdAddr),
  .baseWrEn   (baseWrEn),
  .baseWrAddr (baseWrAddr)
);

// File: tb/lsagu_bench.sv
module lsagu_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [2:0]  reqMode = '0;
  logic [31:0] reqImm = '0;
  logic [4:0]  reqBase = '0, reqIndex = '0, reqDest = '0;
  logic        busy, illegalMode, memReqValid, rdWrEn, baseWrEn;
  logic [4:0]  rfAddrA, rfAddrB, rdAddr, baseWrAddr;
  logic [31:0] rfDataA, rfDataB, memAddr, rdData, baseWrData;
  logic        memRspValid = 1'b0;
  logic [31:0] memRspData = '0;

  always #2 clk = ~clk;  // 250 MHz

  lsagu u_lsagu (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqMode(reqMode),
    .reqImm(reqImm), .reqBase(reqBase), .reqIndex(reqIndex), .reqDest(reqDest),
    .busy(busy), .illegalMode(illegalMode),
    .rfAddrA(rfAddrA), .rfDataA(rfDataA), .rfAddrB(rfAddrB), .rfDataB(rfDataB),
    .memReqValid(memReqValid), .memAddr(memAddr),
    .memRspValid(memRspValid), .memRspData(memRspData),
    .rdWrEn(rdWrEn), .rdAddr(rdAddr), .rdData(rdData),
    .baseWrEn(baseWrEn), .baseWrAddr(baseWrAddr), .baseWrData(baseWrData)
  );

  int nChecks = 0;
  int nFail   = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] memWord(input logic [31:0] a);
    return {a[15:0], ~a[15:0]} ^ 32'h1357_9BDF;
  endfunction

  // register file model; register 0 returns junk so that the block must mask it
  logic [31:0] rf [32];
  assign rfDataA = (rfAddrA == 5'd0) ? 32'hBAD0_0BAD : rf[rfAddrA];
  assign rfDataB = (rfAddrB == 5'd0) ? 32'hBAD1_1BAD : rf[rfAddrB];

  // memory model with programmable latency
  int          lat = 0;
  int          accCount = 0;
  int          rspIdle = 0;
  logic [31:0] lastAddr = '0, prevAddr = '0, pendAddr = '0;
  bit          pending = 0;
  int          cnt = 0;

  always @(negedge clk) begin
    memRspValid = 1'b0;
    if (pending) begin
      if (cnt == 0) begin
        memRspValid = 1'b1;
        memRspData  = memWord(pendAddr);
        pending     = 0;
        if (!busy) rspIdle++;
      end else cnt--;
    end
    if (rstN && memReqValid) begin
      pending  = 1;
      pendAddr = memAddr;
      cnt      = lat;
      accCount++;
      prevAddr = lastAddr;
      lastAddr = memAddr;
    end
    if (rstN && rdWrEn && rdAddr != 5'd0) rf[rdAddr] = rdData;
    if (rstN && baseWrEn && baseWrAddr != 5'd0) rf[baseWrAddr] = baseWrData;
  end

  task automatic doOp(input logic [2:0] m, input logic [31:0] imm,
                      input logic [4:0] b, input logic [4:0] x, input logic [4:0] d,
                      input int l, input bit intrude, input string tagIn);
    logic [31:0] bv, xv, ea, fin, expD, expNb;
    int          expAcc, acc0, extra;
    bit          expBwe, got, ill, gBwe;
    logic [31:0] gD, gBd;
    logic [4:0]  gA, gBa;
    string       tag;
    bv = (b == 5'd0) ? 32'h0 : rf[b];
    xv = (x == 5'd0) ? 32'h0 : rf[x];
    case (m)
      3'd0:    ea = imm;
      3'd2:    ea = bv + imm;
      3'd3:    ea = bv + xv;
      default: ea = bv;
    endcase
    fin    = (m == 3'd4) ? memWord(bv) : ea;
    expAcc = (m == 3'd4) ? 2 : 1;
    expD   = memWord(fin);
    expBwe = (m == 3'd5) && (b != d);
    expNb  = imm[0] ? bv - 32'd4 : bv + 32'd4;
    tag    = tagIn;
    lat    = l;
    @(negedge clk);
    reqValid = 1'b1; reqMode = m; reqImm = imm; reqBase = b; reqIndex = x; reqDest = d;
    acc0 = accCount;
    @(negedge clk);
    if (intrude) begin
      reqMode = 3'd0; reqImm = 32'h7777_0000; reqDest = 5'd30;
    end else reqValid = 1'b0;
    got = 0; ill = 0; gD = '0; gA = '0; gBwe = 0; gBa = '0; gBd = '0;
    for (int i = 0; i < 200 && !got; i++) begin
      if (illegalMode) ill = 1;
      if (rdWrEn) begin
        got = 1; gD = rdData; gA = rdAddr; gBwe = baseWrEn; gBa = baseWrAddr; gBd = baseWrData;
      end else @(negedge clk);
    end
    reqValid = 1'b0;
    chk({tag, " result produced"}, 32'(got), 32'd1);
    chk({tag, " no illegal flag"}, 32'(ill), 32'd0);
    chk({tag, " final address"}, lastAddr, fin);
    chk({tag, " loaded data"}, gD, expD);
    chk("R11 destination number", 32'(gA), 32'(d));
    if (m == 3'd4) chk("R5 first pointer access", prevAddr, bv);
    chk({tag, " base write enable"}, 32'(gBwe), 32'(expBwe));
    if (expBwe) begin
      chk("R6 base write number", 32'(gBa), 32'(b));
      chk("R6 updated base", gBd, expNb);
    end
    extra = 0;
    repeat (3) begin
      @(negedge clk);
      if (rdWrEn || baseWrEn) extra++;
    end
    chk(intrude ? "R10 access count" : {tag, " access count"}, 32'(accCount - acc0), 32'(expAcc));
    chk(intrude ? "R10 no stray write" : "R11 single write", 32'(extra), 32'd0);
  endtask

  task automatic doBad(input logic [2:0] m);
    int acc0, pulses, wr;
    @(negedge clk);
    reqValid = 1'b1; reqMode = m; reqImm = 32'h40; reqBase = 5'd5; reqDest = 5'd6;
    acc0 = accCount;
    @(negedge clk);
    reqValid = 1'b0;
    pulses = 0; wr = 0;
    for (int i = 0; i < 6; i++) begin
      if (illegalMode) pulses++;
      if (rdWrEn || baseWrEn) wr++;
      @(negedge clk);
    end
    chk("R8 illegal pulse count", 32'(pulses), 32'd1);
    chk("R8 no memory access", 32'(accCount - acc0), 32'd0);
    chk("R8 no register write", 32'(wr), 32'd0);
  endtask

  // stimulus: {mode, imm, base, index, dest, latency}
  localparam int NV = 15;
  localparam logic [52:0] VEC [NV] = '{
    {3'd0, 32'h0000_2000, 5'd0,  5'd0,  5'd3,  3'd0},
    {3'd0, 32'hFFFF_FFFC, 5'd1,  5'd2,  5'd4,  3'd2},
    {3'd1, 32'h0000_0000, 5'd5,  5'd0,  5'd6,  3'd0},
    {3'd1, 32'h0000_0000, 5'd0,  5'd0,  5'd7,  3'd1},
    {3'd2, 32'h0000_0010, 5'd8,  5'd0,  5'd9,  3'd0},
    {3'd2, 32'hFFFF_FFF0, 5'd10, 5'd0,  5'd11, 3'd1},
    {3'd2, 32'h0000_0300, 5'd0,  5'd0,  5'd12, 3'd0},
    {3'd3, 32'h0000_0000, 5'd13, 5'd14, 5'd15, 3'd0},
    {3'd3, 32'h0000_0000, 5'd16, 5'd0,  5'd17, 3'd2},
    {3'd4, 32'h0000_0000, 5'd18, 5'd0,  5'd19, 3'd0},
    {3'd4, 32'h0000_0000, 5'd20, 5'd0,  5'd21, 3'd3},
    {3'd5, 32'h0000_0000, 5'd22, 5'd0,  5'd23, 3'd0},
    {3'd5, 32'h0000_0001, 5'd22, 5'd0,  5'd24, 3'd1},
    {3'd5, 32'h0000_0000, 5'd0,  5'd0,  5'd25, 3'd0},
    {3'd2, 32'h0000_0004, 5'd3,  5'd0,  5'd3,  3'd0}
  };

  function automatic string modeTag(input logic [2:0] m, input logic [4:0] b, input logic [4:0] x);
    if (b == 5'd0 || (m == 3'd3 && x == 5'd0)) return "R9";
    case (m)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic finish();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    for (int i = 0; i < 32; i++) rf[i] = (i == 0) ? 32'h0 : 32'h1000 + 32'(i) * 32'h40;
    repeat (3) @(negedge clk);
    // R12 outputs quiet in reset
    chk("R12 busy in reset", 32'(busy), 32'd0);
    chk("R12 request in reset", 32'(memReqValid), 32'd0);
    chk("R12 writes in reset", 32'({rdWrEn, baseWrEn}), 32'd0);
    chk("R12 illegal in reset", 32'(illegalMode), 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R12 idle after reset", 32'(busy), 32'd0);

    for (int v = 0; v < NV; v++) begin
      logic [52:0] e;
      e = VEC[v];
      doOp(e[52:50], e[49:18], e[17:13], e[12:8], e[7:3], int'(e[2:0]), 1'b0,
           modeTag(e[52:50], e[17:13], e[12:8]));
    end

    // R7: destination equals base in auto-update; then read through that register
    doOp(3'd5, 32'h0, 5'd26, 5'd0, 5'd26, 1, 1'b0, "R7");
    doOp(3'd1, 32'h0, 5'd26, 5'd0, 5'd2, 0, 1'b0, "R7");

    // R8: both reserved codes
    doBad(3'd6);
    doBad(3'd7);

    // R10: competing request held during a slow pointer load
    doOp(3'd4, 32'h0, 5'd27, 5'd0, 5'd28, 4, 1'b1, "R5");
    chk("R5 response while idle", 32'(rspIdle), 32'd0);

    finish();
  end

endmodule